// File: doc/BRIEF.md
# Configurable Stream Pipeline Stage

This block sits on one ready/valid stream channel that carries a data word and an end-of-packet flag. It breaks the timing path between the upstream and downstream logic. A single elaboration parameter picks how it does so. Each choice gives a different balance between the number of flops it spends, the cycles of latency it adds and the beats per cycle it sustains.

Four variants are available. The full variant is a two-entry skid buffer driven by a three-state machine: `SK_EMPTY`, `SK_ONE` and `SK_TWO`. Its transitions are:

- fill: `SK_EMPTY` to `SK_ONE` when a beat is accepted.
- pass: `SK_ONE` to `SK_ONE` when a beat enters and a beat leaves in the same cycle.
- park: `SK_ONE` to `SK_TWO` when a beat enters while the output is stalled.
- unpark: `SK_TWO` to `SK_ONE` when the output drains the head beat.
- drain: `SK_ONE` to `SK_EMPTY` when the only beat leaves and nothing enters.

The light variant keeps one holding register with two states, `LT_EMPTY` and `LT_FULL`. It moves from `LT_EMPTY` to `LT_FULL` through load, and from `LT_FULL` back to `LT_EMPTY` through unload. It accepts input only while it is in `LT_EMPTY`.

The pass variant is plain wiring. The deep variant chains three skid-buffer stages for long routing paths.

Top module: `stream_pipe_stage`

## Requirements
- R1: With MODE=MODE_FULL (0), a beat accepted at a clock edge is presented at the output right after that edge. The stage adds one cycle of latency.
- R2: With MODE=MODE_FULL and the output always ready, the stage accepts a beat on every cycle. Sixteen consecutive beats are taken in 16 cycles.
- R3: With MODE=MODE_FULL, starting empty with the output stalled, the stage accepts exactly two beats and then holds input ready low.
- R4: With MODE=MODE_LITE (1), latency is one cycle. Input ready is low in the cycle after every accepted beat, so 16 beats take 31 cycles. With the output stalled, the stage holds only one beat.
- R5: With MODE=MODE_BYPASS (2), the output valid, data and last equal the input in the same cycle, and input ready equals output ready.
- R6: With MODE=MODE_DEEP (3), latency is three cycles and a beat is still accepted on every cycle when the output is always ready.
- R7: With MODE=MODE_DEEP, the stage absorbs up to six beats while the output is stalled, and it loses none of them when the output resumes.
- R8: In every registered mode, while output valid is high and output ready is low, output valid stays high and the output data and last stay unchanged on the next cycle.
- R9: Reset, synchronous and active high, clears every valid flag: output valid is low after reset, including when the stage was full beforehand.
- R10: Beats leave in the order they entered, and each last flag stays attached to its own data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Upstream beat valid |
| s_ready | output | 1 | Stage can take a beat |
| s_data | input | DATA_W | Upstream data word |
| s_last | input | 1 | Upstream end-of-packet flag |
| m_valid | output | 1 | Downstream beat valid |
| m_ready | input | 1 | Downstream can take a beat |
| m_data | output | DATA_W | Downstream data word |
| m_last | output | 1 | Downstream end-of-packet flag |

## Verification
The bench builds four instances side by side with DATA_W=16, one for each MODE value 0 to 3. This lets every variant face the same latency, streaming, stall, reset and random-handshake phases. Because the deep build is included, the six-beat stall capacity and the three-cycle latency can be reached. The light build exposes the bubble pattern, and the pass build allows cycle-exact equality checks between its two sides.

// File: rtl/pipe_pkg.sv
package pipe_pkg;
    typedef enum logic [1:0] {
        MODE_FULL   = 2'd0,
        MODE_LITE   = 2'd1,
        MODE_BYPASS = 2'd2,
        MODE_DEEP   = 2'd3
    } stage_mode_e;

    typedef enum logic [1:0] {
        SK_EMPTY = 2'd0,
        SK_ONE   = 2'd1,
        SK_TWO   = 2'd2
    } skid_state_e;

    typedef enum logic {
        LT_EMPTY = 1'b0,
        LT_FULL  = 1'b1
    } lite_state_e;

    localparam int DEEP_STAGES = 3;
endpackage

// File: rtl/pipe_skid.sv
module pipe_skid #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         s_valid,
    output logic         s_ready,
    input  logic [W-1:0] s_data,
    output logic         m_valid,
    input  logic         m_ready,
    output logic [W-1:0] m_data
);
    import pipe_pkg::*;

    skid_state_e state_q, state_d;
    logic [W-1:0] head_q, spare_q;
    logic in_fire, out_fire;

    assign in_fire  = s_valid && s_ready;
    assign out_fire = m_valid && m_ready;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SK_EMPTY: if (in_fire) state_d = SK_ONE;                       // fill
            SK_ONE: begin
                if (in_fire && !out_fire)      state_d = SK_TWO;           // park
                else if (!in_fire && out_fire) state_d = SK_EMPTY;         // drain
            end
            SK_TWO:   if (out_fire) state_d = SK_ONE;                      // unpark
            default:  state_d = SK_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= SK_EMPTY;
        else     state_q <= state_d;
    end

    // data registers
    always_ff @(posedge clk) begin
        unique case (state_q)
            SK_EMPTY: if (in_fire) head_q <= s_data;
            SK_ONE: begin
                if (in_fire && out_fire) head_q  <= s_data;
                else if (in_fire)        spare_q <= s_data;
            end
            SK_TWO:   if (out_fire) head_q <= spare_q;
            default:  ;
        endcase
    end

    // outputs
    always_comb begin
        s_ready = (state_q != SK_TWO);
        m_valid = (state_q != SK_EMPTY);
        m_data  = head_q;
    end

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

    assert_one_cycle_R1: assert property (@(posedge clk) disable iff (rst)
        (s_valid && s_ready) |=> m_valid);
endmodule

// File: rtl/pipe_lite.sv
module pipe_lite #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         s_valid,
    output logic         s_ready,
    input  logic [W-1:0] s_data,
    output logic         m_valid,
    input  logic         m_ready,
    output logic [W-1:0] m_data
);
    import pipe_pkg::*;

    lite_state_e state_q, state_d;
    logic [W-1:0] hold_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LT_EMPTY: if (s_valid) state_d = LT_FULL;   // load
            LT_FULL:  if (m_ready) state_d = LT_EMPTY;  // unload
            default:  state_d = LT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= LT_EMPTY;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (state_q == LT_EMPTY && s_valid) hold_q <= s_data;
    end

    always_comb begin
        s_ready = (state_q == LT_EMPTY);
        m_valid = (state_q == LT_FULL);
        m_data  = hold_q;
    end

    assert_bubble_R4: assert property (@(posedge clk) disable iff (rst)
        (s_valid && s_ready) |=> !s_ready);

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
endmodule

// File: rtl/pipe_deep.sv
module pipe_deep #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         s_valid,
    output logic         s_ready,
    input  logic [W-1:0] s_data,
    output logic         m_valid,
    input  logic         m_ready,
    output logic [W-1:0] m_data
);
    localparam int N = pipe_pkg::DEEP_STAGES;

    logic         v [N+1];
    logic         r [N+1];
    logic [W-1:0] d [N+1];

    assign v[0]    = s_valid;
    assign d[0]    = s_data;
    assign s_ready = r[0];
    assign m_valid = v[N];
    assign m_data  = d[N];
    assign r[N]    = m_ready;

    for (genvar k = 0; k < N; k++) begin : g_hop
        pipe_skid #(.W(W)) u_hop (
            .clk    (clk),
            .rst    (rst),
            .s_valid(v[k]),
            .s_ready(r[k]),
            .s_data (d[k]),
            .m_valid(v[k+1]),
            .m_ready(r[k+1]),
            .m_data (d[k+1])
        );
    end
endmodule

// File: rtl/stream_pipe_stage.sv
module stream_pipe_stage #(
    parameter int                    DATA_W = 16,
    parameter pipe_pkg::stage_mode_e MODE   = pipe_pkg::MODE_FULL
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_last,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [DATA_W-1:0] m_data,
    output logic              m_last
);
    import pipe_pkg::*;

    localparam int W = DATA_W + 1;

    logic [W-1:0] in_beat, out_beat;

    assign in_beat = {s_last, s_data};
    assign {m_last, m_data} = out_beat;

    if (MODE == MODE_BYPASS) begin : g_wire
        assign m_valid  = s_valid;
        assign out_beat = in_beat;
        assign s_ready  = m_ready;
    end else if (MODE == MODE_LITE) begin : g_lite
        pipe_lite #(.W(W)) u_core (
            .clk(clk), .rst(rst),
            .s_valid(s_valid), .s_ready(s_ready), .s_data(in_beat),
            .m_valid(m_valid), .m_ready(m_ready), .m_data(out_beat)
        );
    end else if (MODE == MODE_DEEP) begin : g_deep
        pipe_deep #(.W(W)) u_core (
            .clk(clk), .rst(rst),
            .s_valid(s_valid), .s_ready(s_ready), .s_data(in_beat),
            .m_valid(m_valid), .m_ready(m_ready), .m_data(out_beat)
        );
    end else begin : g_full
        pipe_skid #(.W(W)) u_core (
            .clk(clk), .rst(rst),
            .s_valid(s_valid), .s_ready(s_ready), .s_data(in_beat),
            .m_valid(m_valid), .m_ready(m_ready), .m_data(out_beat)
        );
    end

    assert_reset_clears_R9: assert property (@(posedge clk)
        (rst && MODE != MODE_BYPASS) |=> !m_valid);
endmodule

// File: tb/tb_stream_pipe_stage.sv
`timescale 1ns/1ps
module tb_stream_pipe_stage;
    import pipe_pkg::*;

    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    int   checks = 0;
    int   fails  = 0;
    bit [3:0] fill_done = '0;
    bit [3:0] lane_done = '0;
    bit   rst_done = 1'b0;
    bit   finished = 1'b0;

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_lat(input int m);
        case (m) 0: return 1; 1: return 1; 2: return 0; default: return 3; endcase
    endfunction
    function automatic int exp_span(input int m);
        return (m == 1) ? 31 : 16;
    endfunction
    function automatic int exp_cap(input int m);
        case (m) 0: return 2; 1: return 1; 2: return 0; default: return 6; endcase
    endfunction
    function automatic string tag_lat(input int m);
        case (m) 0: return "R1"; 1: return "R4"; 2: return "R5"; default: return "R6"; endcase
    endfunction
    function automatic string tag_rate(input int m);
        case (m) 0: return "R2"; 1: return "R4"; 2: return "R5"; default: return "R6"; endcase
    endfunction
    function automatic string tag_cap(input int m);
        case (m) 0: return "R3"; 1: return "R4"; 2: return "R5"; default: return "R7"; endcase
    endfunction

    for (genvar g = 0; g < 4; g++) begin : g_lane
        localparam stage_mode_e LM = stage_mode_e'(g);

        logic          s_valid = 1'b0, s_ready, s_last = 1'b0;
        logic          m_valid, m_ready = 1'b0, m_last;
        logic [DW-1:0] s_data = '0, m_data;
        logic [DW:0]   q[$];
        logic [DW:0]   prev_beat = '0;
        int            seq = 0, cyc = 0;
        bit            last_in = 0, last_out = 0, prev_in = 0, prev_hold = 0;

        stream_pipe_stage #(.DATA_W(DW), .MODE(LM)) dut (
            .clk(clk), .rst(rst),
            .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
            .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last)
        );

        task automatic step(input bit v, input bit r);
            logic [DW:0] exp_beat;
            @(negedge clk);
            s_valid = v;
            m_ready = r;
            s_data  = DW'(seq * 37 + g * 1000);
            s_last  = (seq % 4 == 3);
            #1;
            last_in  = s_valid && s_ready;
            last_out = m_valid && m_ready;
            if (LM == MODE_BYPASS) begin
                check(m_valid == s_valid && m_data == s_data && m_last == s_last
                      && s_ready == m_ready, "R5", "pass-through equality",
                      {m_valid, m_ready}, {s_valid, s_ready});
            end else if (prev_hold) begin
                check(m_valid && {m_last, m_data} == prev_beat, "R8",
                      "held beat stable", {m_last, m_data}, prev_beat);
            end
            if (LM == MODE_LITE && prev_in)
                check(!s_ready, "R4", "bubble after accept", s_ready, 0);
            if (last_in) q.push_back({s_last, s_data});
            if (last_out) begin
                if (q.size() == 0) begin
                    check(1'b0, "R10", "beat out with empty scoreboard", {m_last, m_data}, -1);
                end else begin
                    exp_beat = q.pop_front();
                    check({m_last, m_data} == exp_beat, "R10", "beat order/last",
                          {m_last, m_data}, exp_beat);
                end
            end
            prev_in   = last_in;
            prev_hold = m_valid && !m_ready;
            prev_beat = {m_last, m_data};
            if (last_in) seq++;
            cyc++;
        endtask

        task automatic drain();
            for (int i = 0; i < 40 && (q.size() != 0 || m_valid); i++) step(1'b0, 1'b1);
            check(q.size() == 0, "R7", "no beat lost after drain", q.size(), 0);
        endtask

        initial begin
            int t0, lat, acc, first, lastc;
            logic [15:0] lf;
            repeat (3) @(negedge clk);
            #1;
            check(!m_valid, "R9", "valid low in reset", m_valid, 0);
            wait (rst == 1'b0);

            // latency from idle
            t0 = -1; lat = -1;
            for (int i = 0; i < 20 && lat < 0; i++) begin
                step(t0 < 0, 1'b1);
                if (last_in && t0 < 0) t0 = cyc;
                if (last_out && t0 >= 0 && lat < 0) lat = cyc - t0;
            end
            check(lat == exp_lat(g), tag_lat(g), "latency", lat, exp_lat(g));
            drain();

            // streaming rate
            acc = 0; first = -1; lastc = 0;
            for (int i = 0; i < 80 && acc < 16; i++) begin
                step(1'b1, 1'b1);
                if (last_in) begin
                    if (first < 0) first = cyc;
                    lastc = cyc;
                    acc++;
                end
            end
            check(lastc - first + 1 == exp_span(g), tag_rate(g), "cycles for 16 beats",
                  lastc - first + 1, exp_span(g));
            drain();

            // stall capacity then release
            acc = 0;
            for (int i = 0; i < 12; i++) begin
                step(1'b1, 1'b0);
                if (last_in) acc++;
            end
            check(acc == exp_cap(g), tag_cap(g), "beats absorbed while stalled", acc, exp_cap(g));
            drain();

            // refill, then reset while full
            for (int i = 0; i < 12; i++) step(1'b1, 1'b0);
            @(negedge clk);
            s_valid = 1'b0;
            m_ready = 1'b0;
            fill_done[g] = 1'b1;
            wait (rst_done);
            @(negedge clk);
            #1;
            check(!m_valid, "R9", "valid low after reset while full", m_valid, 0);
            q.delete();
            prev_hold = 0;
            prev_in   = 0;

            // random handshakes
            lf = 16'hACE1 ^ 16'(g * 77);
            for (int i = 0; i < 400; i++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                step(lf[0] | lf[3], lf[5] | lf[7]);
            end
            drain();
            lane_done[g] = 1'b1;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        wait (&fill_done);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        rst_done = 1'b1;
        wait (&lane_done);
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule